// File: doc/BRIEF.md
# Memory-Card Command Token Transmitter

This block sends host-to-card commands over a single command wire. A command index and a 32-bit argument arrive on a parallel request port with a valid/ready handshake. The block builds a fixed 48-bit token from them and shifts it out most-significant bit first, one bit per clock-enable tick. The token has a low start bit, a high direction bit that marks host-to-card traffic, the index, the argument, a 7-bit checksum and a high stop bit.

The 7-bit CRC is accumulated serially while the first 40 bits leave the block. It is then shifted out directly, so the whole token never has to be stored. Between tokens the wire is released: the drive enable is low and the data output rests high. A one-cycle completion pulse tells the controller that it may issue the next command. The tick input lets the wire run at any fraction of the system clock.

Top module: `cmd_token_tx`

## Requirements
- R1: While reset is held and while idle, `line_out` is 1, `line_drive` is 0, `done` is 0 and `req_ready` is 1; `line_drive` is never 0 while `line_out` is 0.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the completion cycle. A `req_valid` raised while `req_ready` is 0 starts nothing.
- R3: After acceptance the token occupies exactly 48 tick intervals. Each bit appears on `line_out`, with `line_drive` at 1, in the cycle after a tick edge.
- R4: Token bit 0 (the first sent) is 0, the start bit. Token bit 1 is 1, the host-to-card direction bit.
- R5: Token bits 2..7 carry the 6-bit index and bits 8..39 carry the 32-bit argument, each field most-significant bit first.
- R6: Token bits 40..46 carry the CRC, most-significant bit first. It uses generator x^7+x^3+1, starts at zero, and is computed over token bits 0..39. Example: index 0 with argument 0 gives 7'h4A.
- R7: Token bit 47 is 1, the stop bit.
- R8: At the tick after the stop bit has been driven, `line_drive` goes to 0 and `line_out` to 1. In that same cycle `done` is 1 for exactly one cycle and `req_ready` returns to 1.
- R9: In a cycle whose edge sees no tick, `line_out` and `line_drive` keep their values.
- R10: A synchronous reset during a token returns the block to the R1 state at the next edge. No `done` pulse and no further driven bits follow.
- R11: `req_index` and `req_arg` are captured at acceptance. Changing them afterwards does not alter the token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate clock enable, one bit per pulse |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| line_out | output | 1 | Command wire data level |
| line_drive | output | 1 | Command wire drive enable; 0 means released |
| done | output | 1 | One-cycle pulse when the token has finished |

## Verification
A wrong bit counter shows up at the ports as a token that is too long or too short. The `done` pulse then falls on the wrong tick, so the error is visible at most one tick after the stop bit should have ended. A corrupted CRC register affects only bits 40..46, so the whole captured frame is compared with an expected value built from the requirements, including published checksums for four common commands. Faults in handshake or reset state show at once on `req_ready`, `line_drive` or `line_out`, within a single clock of the stimulus.

// File: rtl/cmdtx_pkg.sv
package cmdtx_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

    typedef enum logic [1:0] {
        PH_BODY   = 2'd0,
        PH_CRC    = 2'd1,
        PH_END    = 2'd2,
        PH_FINISH = 2'd3
    } tx_phase_e;

endpackage

// File: rtl/cmdtx_bitcnt.sv
// Position counter for the outgoing token; reports which field is next.
module cmdtx_bitcnt
    import cmdtx_pkg::*;
#(
    parameter int BODY_BITS = 40,
    parameter int CRC_BITS  = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      adv,
    output tx_phase_e phase
);
    localparam int TOKEN_BITS = BODY_BITS + CRC_BITS + 1;
    localparam int CNT_W      = $clog2(TOKEN_BITS + 1);
    localparam logic [CNT_W-1:0] CRC_POS = CNT_W'(BODY_BITS);
    localparam logic [CNT_W-1:0] END_POS = CNT_W'(BODY_BITS + CRC_BITS);
    localparam logic [CNT_W-1:0] FIN_POS = CNT_W'(TOKEN_BITS);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (adv && (cnt_q != FIN_POS)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        if (cnt_q < CRC_POS) begin
            phase = PH_BODY;
        end else if (cnt_q < END_POS) begin
            phase = PH_CRC;
        end else if (cnt_q < FIN_POS) begin
            phase = PH_END;
        end else begin
            phase = PH_FINISH;
        end
    end

    // R3: the position never runs past the completion slot
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FIN_POS);

    // R3: every tick inside the token moves exactly one position
    assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv && !clear && (phase != PH_FINISH)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/cmdtx_crc_ser.sv
// Serial CRC: absorbs data bits, then drains its remainder MSB first.
module cmdtx_crc_ser #(
    parameter int             W    = 7,
    parameter logic [W-1:0]   POLY = 7'h09
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic feed,
    input  logic drain,
    input  logic din,
    output logic msb
);
    logic [W-1:0] crc_d, crc_q;
    logic [W-1:0] fed;
    logic         fb;

    assign fb = din ^ crc_q[W-1];

    generate
        for (genvar i = 0; i < W; i++) begin : g_tap
            if (i == 0) begin : g_low
                assign fed[i] = POLY[i] & fb;
            end else begin : g_up
                assign fed[i] = crc_q[i-1] ^ (POLY[i] & fb);
            end
        end
    endgenerate

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (feed) begin
            crc_d = fed;
        end else if (drain) begin
            crc_d = {crc_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign msb = crc_q[W-1];

    // R6: absorbing and draining never happen in the same cycle
    assert_crc_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(feed && drain));

    // R6: draining pushes zeros in from the bottom
    assert_crc_drain_R6: assert property (@(posedge clk) disable iff (rst)
        (drain && !clear && !feed) |=> (crc_q[0] == 1'b0));

endmodule

// File: rtl/cmd_token_tx.sv
module cmd_token_tx
    import cmdtx_pkg::*;
#(
    parameter int               IDX_W    = 6,
    parameter int               ARG_W    = 32,
    parameter int               CRC_W    = 7,
    parameter logic [CRC_W-1:0] CRC_POLY = 7'h09
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_index,
    input  logic [ARG_W-1:0] req_arg,
    output logic             line_out,
    output logic             line_drive,
    output logic             done
);
    localparam int BODY_W = 2 + IDX_W + ARG_W;

    typedef struct packed {
        tx_state_e         state;
        logic [BODY_W-1:0] body;
        logic              line;
        logic              drive;
        logic              done;
    } tx_regs_t;

    localparam tx_regs_t REGS_IDLE = '{
        state: ST_IDLE,
        body:  '0,
        line:  1'b1,
        drive: 1'b0,
        done:  1'b0
    };

    tx_regs_t  regs_d, regs_q;
    tx_phase_e phase;
    logic      accept;
    logic      cnt_adv;
    logic      crc_feed;
    logic      crc_drain;
    logic      crc_msb;

    cmdtx_bitcnt #(
        .BODY_BITS (BODY_W),
        .CRC_BITS  (CRC_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .adv   (cnt_adv),
        .phase (phase)
    );

    cmdtx_crc_ser #(
        .W    (CRC_W),
        .POLY (CRC_POLY)
    ) u_crc (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .feed  (crc_feed),
        .drain (crc_drain),
        .din   (regs_q.body[BODY_W-1]),
        .msb   (crc_msb)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.done = 1'b0;
        accept    = 1'b0;
        cnt_adv   = 1'b0;
        crc_feed  = 1'b0;
        crc_drain = 1'b0;
        unique case (regs_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    accept       = 1'b1;
                    regs_d.state = ST_SEND;
                    regs_d.body  = {1'b0, 1'b1, req_index, req_arg};
                end
            end
            ST_SEND: begin
                if (tick) begin
                    cnt_adv = 1'b1;
                    unique case (phase)
                        PH_BODY: begin
                            regs_d.line  = regs_q.body[BODY_W-1];
                            regs_d.drive = 1'b1;
                            regs_d.body  = {regs_q.body[BODY_W-2:0], 1'b0};
                            crc_feed     = 1'b1;
                        end
                        PH_CRC: begin
                            regs_d.line = crc_msb;
                            crc_drain   = 1'b1;
                        end
                        PH_END: begin
                            regs_d.line = 1'b1;
                        end
                        PH_FINISH: begin
                            regs_d.line  = 1'b1;
                            regs_d.drive = 1'b0;
                            regs_d.done  = 1'b1;
                            regs_d.state = ST_IDLE;
                        end
                        default: regs_d = REGS_IDLE;
                    endcase
                end
            end
            default: regs_d = REGS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= REGS_IDLE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign req_ready  = (regs_q.state == ST_IDLE);
    assign line_out   = regs_q.line;
    assign line_drive = regs_q.drive;
    assign done       = regs_q.done;

    // R1: a released wire always rests high
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        !line_drive |-> line_out);

    // R2: while able to accept, the wire is never driven
    assert_ready_release_R2: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !line_drive);

    // R2: a taken request makes the block busy on the next cycle
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: the first driven level of a token is the start bit
    assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(line_drive) |-> !line_out);

    // R7: the last driven level of a completed token is high
    assert_end_high_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(line_drive) && !$past(rst)) |-> $past(line_out));

    // R8: completion pulse lasts one cycle
    assert_done_once_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion coincides with release and readiness
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && !line_drive));

    // R9: without a tick the wire holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(line_out) && $stable(line_drive)));

    // R10: reset leaves the block idle with no completion
    assert_abort_R10: assert property (@(posedge clk)
        rst |=> (!done && !line_drive && line_out && req_ready));

endmodule

// File: tb/tb_cmd_token_tx.sv
`timescale 1ns/1ps
module tb_cmd_token_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [5:0]  req_index = '0;
    logic [31:0] req_arg = '0;
    logic        line_out;
    logic        line_drive;
    logic        done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmd_token_tx dut (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_index  (req_index),
        .req_arg    (req_arg),
        .line_out   (line_out),
        .line_drive (line_drive),
        .done       (done)
    );

    // {checksum known, index, argument, checksum}
    localparam logic [45:0] VECS [7] = '{
        {1'b1, 6'd0,  32'h0000_0000, 7'h4A},
        {1'b1, 6'd8,  32'h0000_01AA, 7'h43},
        {1'b1, 6'd17, 32'h0000_0000, 7'h2A},
        {1'b1, 6'd55, 32'h0000_0000, 7'h32},
        {1'b0, 6'd63, 32'hFFFF_FFFF, 7'h00},
        {1'b0, 6'd42, 32'hA5C3_0F96, 7'h00},
        {1'b0, 6'd1,  32'h8000_0001, 7'h00}
    };

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc_ref(input logic [39:0] bits);
        logic [6:0] r;
        r = '0;
        for (int k = 39; k >= 0; k--) begin
            logic f;
            f = bits[k] ^ r[6];
            r = {r[5:0], 1'b0};
            if (f) r = r ^ 7'h09;
        end
        return r;
    endfunction

    task automatic pulse_tick();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a falling edge. Sends one token and checks it bit by bit.
    task automatic send_token(input logic [5:0] idx, input logic [31:0] arg,
                              input int gap, input logic [6:0] crc_exp,
                              input bit poke);
        logic [47:0] got;
        logic [47:0] exp;
        bit hold_ok;
        bit drv_ok;
        logic prev_line;
        logic prev_drv;
        exp = {1'b0, 1'b1, idx, arg, crc_exp, 1'b1};
        got = '0;
        req_valid = 1'b1;
        req_index = idx;
        req_arg   = arg;
        @(posedge clk);
        @(negedge clk);
        req_valid = poke;
        req_index = ~idx;      // R11: later changes must not matter
        req_arg   = ~arg;
        check(!req_ready && !line_drive && line_out, "R2 accept",
              {61'd0, req_ready, line_drive, line_out}, 64'b001);
        hold_ok = 1'b1;
        drv_ok  = 1'b1;
        prev_line = line_out;
        prev_drv  = line_drive;
        for (int b = 0; b < 48; b++) begin
            for (int g = 0; g < gap; g++) begin
                idle_cycle();
                if (line_out !== prev_line || line_drive !== prev_drv) hold_ok = 1'b0;
            end
            pulse_tick();
            got[47-b] = line_out;
            if (line_drive !== 1'b1 || done !== 1'b0) drv_ok = 1'b0;
            prev_line = line_out;
            prev_drv  = line_drive;
        end
        req_valid = 1'b0;
        check(hold_ok, "R9 hold between ticks", {63'd0, hold_ok}, 64'd1);
        check(drv_ok, "R3 driven for 48 ticks", {63'd0, drv_ok}, 64'd1);
        check(got == exp, "R4 R5 R6 R7 R11 frame", {16'd0, got}, {16'd0, exp});
        for (int g = 0; g < gap; g++) idle_cycle();
        pulse_tick();
        check(done && !line_drive && line_out && req_ready, "R8 completion",
              {60'd0, done, line_drive, line_out, req_ready}, 64'b1011);
        idle_cycle();
        check(!done, "R8 single pulse", {63'd0, done}, 64'd0);
        if (poke) begin
            bit quiet;
            quiet = 1'b1;
            repeat (5) begin
                pulse_tick();
                if (line_drive || done || !req_ready) quiet = 1'b0;
            end
            check(quiet, "R2 busy request ignored", {63'd0, quiet}, 64'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state during reset
        check(line_out && !line_drive && !done && req_ready, "R1 reset state",
              {60'd0, line_out, line_drive, done, req_ready}, 64'b1001);
        rst = 1'b0;
        idle_cycle();
        pulse_tick();
        check(line_out && !line_drive && !done && req_ready, "R1 idle with tick",
              {60'd0, line_out, line_drive, done, req_ready}, 64'b1001);

        // Table walk
        for (int i = 0; i < 7; i++) begin
            logic [6:0] c;
            c = VECS[i][45] ? VECS[i][6:0]
                            : crc_ref({1'b0, 1'b1, VECS[i][44:39], VECS[i][38:7]});
            send_token(VECS[i][44:39], VECS[i][38:7], i % 3, c, 1'b0);
        end

        // R2: request held while busy
        send_token(6'd12, 32'hDEAD_BEEF, 1,
                   crc_ref({2'b01, 6'd12, 32'hDEAD_BEEF}), 1'b1);

        // R10: reset in the middle of a token
        req_valid = 1'b1;
        req_index = 6'd5;
        req_arg   = 32'h0000_1234;
        idle_cycle();
        req_valid = 1'b0;
        repeat (10) pulse_tick();
        check(line_drive, "R10 token underway", {63'd0, line_drive}, 64'd1);
        rst = 1'b1;
        idle_cycle();
        rst = 1'b0;
        check(!line_drive && line_out && req_ready && !done, "R10 abort state",
              {60'd0, line_drive, line_out, req_ready, done}, 64'b0110);
        begin
            bit silent;
            silent = 1'b1;
            repeat (45) begin
                pulse_tick();
                if (done || line_drive) silent = 1'b0;
            end
            check(silent, "R10 nothing after abort", {63'd0, silent}, 64'd1);
        end

        // Back-to-back after abort, tick every cycle
        send_token(6'd0, 32'h0, 0, 7'h4A, 1'b0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule